// File: doc/BRIEF.md
# Packed Colour Lookup Table

A 256-entry colour lookup table for a display pipeline. Software fills it through a register window of 128 32-bit words. Each word carries two 16-bit colour codes, so a single write updates two table entries. Every code holds three 5-bit colour fields and an intensity flag that the table drops. The block keeps the raw words exactly as written so software can read them back. On each write it also builds two 24-bit colours, each field widened to 8 bits.

The pixel side gives an 8-bit index and receives the widened colour one clock later. A byte-order input picks which 5-bit field goes to the top byte of the output. A write and a lookup may fall in the same cycle without stalling either one.

Top module: `palette_ram`

## Requirements
- R1: The window covers byte addresses 0x200 to 0x3FF, which is `addr[11:9] == 3'b001`, and the word index is `addr[8:2]`. A write outside the window changes neither the stored words nor the colours.
- R2: A read strobe returns, one cycle later on `rdata`, the 32-bit word last written to that index. A read outside the window returns 0. A read and a write to the same word in the same cycle return the old word.
- R3: Word n holds entry 2n in bits [15:0] and entry 2n+1 in bits [31:16]. One write updates both entries.
- R4: In each 16-bit code, field A is bits [4:0], green is bits [9:5] and field C is bits [14:10]. Bit 15 is ignored. Each field is widened to 8 bits by shifting it left by 3, so the low three bits are zero.
- R5: The lookup output `lut_rgb` is registered and reflects the index from the previous cycle. With `bgr` low its layout is {A, green, C}, from bits [23:16] down to [7:0].
- R6: With `bgr` high, sampled together with the index, the layout is {C, green, A}.
- R7: A lookup of an entry whose word is being written in the same cycle returns the colour from before the write.
- R8: Reset (`rst_n` low) clears all stored words, all colours, `rdata` and `lut_rgb` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register access |
| wdata | input | 32 | Write data, two packed colour codes |
| rdata | output | 32 | Read data, valid one cycle after `rd_en` |
| lut_idx | input | 8 | Pixel index for the lookup |
| bgr | input | 1 | Swaps fields A and C on the lookup output |
| lut_rgb | output | 24 | Widened colour, one cycle after `lut_idx` |

## Verification
The register write and the pixel lookup can act on the same table entry in one clock. The bench provokes this by writing a new word while it looks up the upper entry of that word in the same cycle. The result must be the colour from before the write. A second lookup of that entry on the next cycle must show the new colour. A read-back issued in the same cycle as a write to the same word is judged the same way: it must return the old word.

// File: rtl/palette_ram.sv
module palette_ram #(
  parameter int AW     = 12,
  parameter int DW     = 32,
  parameter int IDX_W  = 8,
  parameter int FLD_W  = 5,
  parameter int WIN_HI = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [IDX_W-1:0]  lut_idx,
  input  logic              bgr,
  output logic [3*8-1:0]    lut_rgb
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int WORDS   = ENTRIES / 2;
  localparam int WI_W    = IDX_W - 1;
  localparam int HW      = DW / 2;

  logic [DW-1:0] raw_q [WORDS];
  logic [23:0]   col_q [ENTRIES];

  logic          hit;
  logic [WI_W-1:0] widx;

  assign hit  = (addr[AW-1:WI_W+2] == (AW-WI_W-2)'(WIN_HI));
  assign widx = addr[WI_W+1:2];

  function automatic logic [23:0] widen(input logic [HW-1:0] code);
    return {code[FLD_W-1:0], 3'b000,
            code[2*FLD_W-1:FLD_W], 3'b000,
            code[3*FLD_W-1:2*FLD_W], 3'b000};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) raw_q[i] <= '0;
      for (int i = 0; i < ENTRIES; i++) col_q[i] <= '0;
    end else if (wr_en && hit) begin
      raw_q[widx]          <= wdata;
      col_q[{widx, 1'b0}]  <= widen(wdata[HW-1:0]);
      col_q[{widx, 1'b1}]  <= widen(wdata[DW-1:HW]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_en)  rdata <= hit ? raw_q[widx] : '0;
  end

  logic [23:0] sel;
  assign sel = col_q[lut_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lut_rgb <= '0;
    else        lut_rgb <= bgr ? {sel[7:0], sel[15:8], sel[23:16]} : sel;
  end
endmodule

module palette_ram_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [11:0] addr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic [7:0]  lut_idx,
  input logic        bgr,
  input logic [23:0] lut_rgb
);
  function automatic logic [23:0] exp_col(input logic [15:0] c);
    return {c[4:0], 3'b0, c[9:5], 3'b0, c[14:10], 3'b0};
  endfunction

  logic in_win;
  assign in_win = addr[11:9] == 3'b001;

  AST_OUT_WIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_win) |=> rdata == 32'h0); // R2

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_win) ##1 (rd_en && !wr_en && addr == $past(addr))
      |=> rdata == $past(wdata, 2)); // R2

  AST_LOW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_win) ##1 (!bgr && lut_idx == {$past(addr[8:2]), 1'b0})
      |=> lut_rgb == exp_col($past(wdata[15:0], 2))); // R4

  AST_HIGH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_win) ##1 (!bgr && lut_idx == {$past(addr[8:2]), 1'b1})
      |=> lut_rgb == exp_col($past(wdata[31:16], 2))); // R3

  AST_BGR_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !bgr) ##1 (bgr && $stable(lut_idx))
      |=> lut_rgb == {$past(lut_rgb[7:0]), $past(lut_rgb[15:8]), $past(lut_rgb[23:16])}); // R6

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_rgb & 24'h070707) == 24'h0); // R4
endmodule

bind palette_ram palette_ram_sva u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .lut_idx(lut_idx), .bgr(bgr), .lut_rgb(lut_rgb)
);

// File: tb/palette_ram_bench.sv
module palette_ram_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, bgr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  lut_idx = '0;
  logic [23:0] lut_rgb;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  palette_ram u_palette_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .lut_idx(lut_idx), .bgr(bgr), .lut_rgb(lut_rgb)
  );

  // {word index, data, upper entry select, expected colour with bgr low}
  localparam int NV = 6;
  localparam logic [63:0] VEC [NV] = '{
    {7'd0,   32'h0000_001F, 1'b0, 24'hF80000},
    {7'd1,   32'h7FFF_0000, 1'b1, 24'hF8F8F8},
    {7'd2,   32'h0000_83E0, 1'b0, 24'h00F800},
    {7'd127, 32'hFC00_0000, 1'b1, 24'h0000F8},
    {7'd64,  32'h0000_1234, 1'b0, 24'hA08820},
    {7'd5,   32'hABCD_0000, 1'b1, 24'h68F050}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    check(tag, rdata, exp);
  endtask

  task automatic look(input logic [7:0] i, input logic b, input logic [23:0] exp, input string tag);
    @(negedge clk); lut_idx = i; bgr = b;
    @(negedge clk); bgr = 1'b0;
    check(tag, {8'h0, lut_rgb}, {8'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 rdata after reset", rdata, 32'h0);
    check("R8 lut_rgb after reset", {8'h0, lut_rgb}, 32'h0);
    rst_n = 1'b1;
    rd(12'h20C, 32'h0, "R8 stored word cleared");
    look(8'd9, 1'b0, 24'h0, "R8 colour cleared");

    for (int k = 0; k < NV; k++) begin
      logic [6:0]  w;  logic [31:0] d;  logic hi;  logic [23:0] e;
      {w, d, hi, e} = VEC[k];
      wr({3'b001, w, 2'b00}, d);
      rd({3'b001, w, 2'b00}, d, "R2 read-back");
      look({w, hi}, 1'b0, e, "R4 R5 widened colour");
    end

    look(8'd1, 1'b0, 24'h0, "R3 upper entry of word 0 zero");
    look(8'd2, 1'b0, 24'h0, "R3 lower entry of word 1 zero");
    look(8'd129, 1'b0, 24'h0, "R3 upper entry of word 64 zero");
    look(8'd128, 1'b1, 24'h2088A0, "R6 swapped layout");
    look(8'd11, 1'b1, 24'h50F068, "R6 swapped upper entry");

    wr(12'h400, 32'h0000_7FFF);
    look(8'd0, 1'b0, 24'hF80000, "R1 write above window ignored");
    wr(12'h1FC, 32'hFFFF_FFFF);
    look(8'd255, 1'b0, 24'h0000F8, "R1 write below window ignored");
    rd(12'h3FC, 32'hFC00_0000, "R1 last word at 0x3FC");
    rd(12'h100, 32'h0, "R2 read outside window");

    // R7: write word 1 while looking up entry 3, then look again
    @(negedge clk); wr_en = 1'b1; addr = 12'h204; wdata = 32'h0000_0000;
    lut_idx = 8'd3; bgr = 1'b0; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check("R7 same-cycle lookup old colour", {8'h0, lut_rgb}, 32'h00F8F8F8);
    check("R2 same-cycle read old word", rdata, 32'h7FFF_0000);
    @(negedge clk);
    check("R7 next lookup new colour", {8'h0, lut_rgb}, 32'h0);

    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    look(8'd10, 1'b0, 24'h0, "R8 reset mid-run clears colours");
    rd(12'h214, 32'h0, "R8 reset mid-run clears words");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule